// File: doc/BRIEF.md
# Transmit Output Squelch and Conditioning

This block sits at the end of a serial transmit data path, just ahead of the serializer. It holds an 8-bit configuration register that is written and read through a simple byte-wide port. Each cycle it takes a parallel data word together with two status flags: loss of signal and loss of lock. From these it produces a registered output word of four possible kinds. The word is either the data unchanged, the data with every bit inverted, all zeros (squelched), or a fixed alternating 1010 word that the serializer turns into a clock-like waveform.

Squelch can come from three sources. One is a forced-squelch bit. The other two are the loss-of-signal and loss-of-lock flags, each gated by its own enable bit. A separate mode swaps in the clock pattern while loss of signal is active. Squelch wins over the clock pattern, and the clock pattern wins over normal data. Inversion applies only to data that is passed through. The register also drives two controls to a neighbouring FIFO: an auto-reset enable level, and a one-cycle manual reset pulse.

The reset input is asserted asynchronously and released synchronously through a two-stage synchronizer inside the block.

Top module: `txout_cond`

## Requirements
- R1: After reset the configuration reads back 0x02, `data_out` is all zeros, `fifo_rst_pulse` is 0 and `fifo_auto_rst_en` is 1.
- R2: Bit 7 of `cfg_rdata` always reads 0, whatever value was written to it.
- R3: When no squelch, clock or invert condition applies, `data_out` equals `data_in` one clock edge after `data_in` is sampled, and not earlier.
- R4: When bit 6 (invert) is set and no squelch or clock condition applies, `data_out` is the bitwise complement of `data_in`.
- R5: When bit 2 (forced squelch) is set, `data_out` is all zeros whatever `los_in` and `lol_in` are.
- R6: When bit 3 (squelch on loss of signal) is set and `los_in` is 1, `data_out` is all zeros. When `los_in` is 0, this bit has no effect.
- R7: When bit 4 (squelch on loss of lock) is set and `lol_in` is 1, `data_out` is all zeros. When bit 4 is clear, `lol_in` has no effect.
- R8: When bit 5 (clock on loss of signal) is set, `los_in` is 1 and no squelch applies, `data_out` is the alternating word with its MSB equal to 1 (0xAAAA at 16 bits). This word is never inverted by bit 6.
- R9: Squelch has priority over the clock pattern. The squelch level is all zeros even when bit 6 is set.
- R10: Writing 1 to bit 0 (manual FIFO reset) sets it for exactly one cycle, which is seen on `fifo_rst_pulse` and in readback. The bit then clears by itself unless it is written to 1 again.
- R11: `fifo_auto_rst_en` follows register bit 1.
- R12: A register write takes effect on the output word one cycle after the write edge, and `cfg_rdata` shows the written bits 6..1 after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback |
| los_in | input | 1 | Loss-of-signal status flag |
| lol_in | input | 1 | Loss-of-lock status flag |
| data_in | input | DATA_W | Parallel transmit data word |
| data_out | output | DATA_W | Conditioned, registered output word |
| fifo_rst_pulse | output | 1 | One-cycle manual FIFO reset |
| fifo_auto_rst_en | output | 1 | FIFO auto-reset enable level |

## Verification
The assertions check the per-cycle rules on every cycle. These are the all-zero level whenever a squelch source was active on the previous edge, the clock word whenever clock mode applied without squelch, the self-clearing of the manual reset bit, the reserved bit reading zero, and write data landing in the register. The bench's scenarios are needed for the rest. That covers the exact reset values, the one-cycle latency shown by sampling before and after an edge, and the absence of inversion on the squelch and clock words. It also covers the cases where a flag must have no effect because its enable is clear.

// File: rtl/txc_pkg.sv
package txc_pkg;

  localparam int CFG_W = 8;

  typedef struct packed {
    logic invert;
    logic clk_on_los;
    logic sq_lol_en;
    logic sq_los_en;
    logic sq_force;
    logic auto_rst;
    logic man_rst;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{invert: 1'b0, clk_on_los: 1'b0, sq_lol_en: 1'b0,
                                 sq_los_en: 1'b0, sq_force: 1'b0, auto_rst: 1'b1,
                                 man_rst: 1'b0};

  typedef enum logic [1:0] {
    OSEL_PASS  = 2'd0,
    OSEL_INV   = 2'd1,
    OSEL_QUIET = 2'd2,
    OSEL_CLK   = 2'd3
  } osel_e;

  function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] b);
    cfg_t c;
    c.invert     = b[6];
    c.clk_on_los = b[5];
    c.sq_lol_en  = b[4];
    c.sq_los_en  = b[3];
    c.sq_force   = b[2];
    c.auto_rst   = b[1];
    c.man_rst    = b[0];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c);
    return {1'b0, c.invert, c.clk_on_los, c.sq_lol_en, c.sq_los_en,
            c.sq_force, c.auto_rst, c.man_rst};
  endfunction

endpackage

// File: rtl/txc_rst_sync.sv
module txc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/txc_cfg_reg.sv
module txc_cfg_reg
  import txc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);

  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d         = cfg_q;
    cfg_d.man_rst = 1'b0;
    if (wr_en) cfg_d = unpack_cfg(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = pack_cfg(cfg_q);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7] == 1'b0);

  assert_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata[6:1] == $past(wdata[6:1]));

  assert_man_rst_self_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.man_rst && !(wr_en && wdata[0])) |=> !cfg_q.man_rst);

endmodule

// File: rtl/txc_out_cond.sv
module txc_out_cond
  import txc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              los,
  input  logic              lol,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] clk_word;
  logic [DATA_W-1:0] dout_d, dout_q;
  logic              quiet, clk_mode;
  osel_e             sel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_clk_word
    assign clk_word[i] = (i % 2) == 1;
  end

  always_comb begin
    quiet    = cfg.sq_force | (cfg.sq_los_en & los) | (cfg.sq_lol_en & lol);
    clk_mode = cfg.clk_on_los & los;
    if (quiet)           sel = OSEL_QUIET;
    else if (clk_mode)   sel = OSEL_CLK;
    else if (cfg.invert) sel = OSEL_INV;
    else                 sel = OSEL_PASS;
  end

  always_comb begin
    unique case (sel)
      OSEL_QUIET: dout_d = '0;
      OSEL_CLK:   dout_d = clk_word;
      OSEL_INV:   dout_d = ~din;
      default:    dout_d = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

  assert_force_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.sq_force |=> dout == '0);

  assert_los_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sq_los_en && los) |=> dout == '0);

  assert_lol_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sq_lol_en && lol) |=> dout == '0);

  assert_clk_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.clk_on_los && los && !cfg.sq_force && !(cfg.sq_los_en && los)
     && !(cfg.sq_lol_en && lol)) |=> $countones(dout) == DATA_W / 2 && dout[DATA_W-1]);

  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.sq_force && !(cfg.sq_los_en && los) && !(cfg.sq_lol_en && lol)
     && !(cfg.clk_on_los && los) && !cfg.invert) |=> dout == $past(din));

endmodule

// File: rtl/txout_cond.sv
module txout_cond
  import txc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              los_in,
  input  logic              lol_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              fifo_rst_pulse,
  output logic              fifo_auto_rst_en
);

  logic rst_core_n;
  cfg_t cfg;

  txc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  txc_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  txc_out_cond #(.DATA_W(DATA_W)) u_cond (
    .clk  (clk),
    .rst_n(rst_core_n),
    .cfg  (cfg),
    .los  (los_in),
    .lol  (lol_in),
    .din  (data_in),
    .dout (data_out)
  );

  assign fifo_rst_pulse   = cfg.man_rst;
  assign fifo_auto_rst_en = cfg.auto_rst;

  assert_pulse_matches_rd_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    fifo_rst_pulse == cfg_rdata[0]);

  assert_auto_en_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    fifo_auto_rst_en == cfg_rdata[1]);

endmodule

// File: tb/txout_cond_bench.sv
module txout_cond_bench;

  localparam int W  = 16;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [7:0]   cfg_wdata = '0;
  logic [7:0]   cfg_rdata;
  logic         los_in = 1'b0;
  logic         lol_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] data_out;
  logic         fifo_rst_pulse;
  logic         fifo_auto_rst_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txout_cond #(.DATA_W(W)) u_txout_cond (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .los_in(los_in), .lol_in(lol_in),
    .data_in(data_in), .data_out(data_out),
    .fifo_rst_pulse(fifo_rst_pulse), .fifo_auto_rst_en(fifo_auto_rst_en)
  );

  // cfg, los, lol, data_in, expected data_out
  localparam logic [7:0]   V_CFG [NV] = '{8'h02, 8'h42, 8'h06, 8'h0A, 8'h0A, 8'h12, 8'h12,
                                          8'h22, 8'h22, 8'h62, 8'h2A, 8'h66, 8'h62};
  localparam logic         V_LOS [NV] = '{0, 0, 1, 1, 0, 0, 1, 1, 0, 1, 1, 0, 0};
  localparam logic         V_LOL [NV] = '{0, 0, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0, 1};
  localparam logic [W-1:0] V_DIN [NV] = '{16'h1234, 16'h1234, 16'hFFFF, 16'h5555, 16'h5555,
                                          16'h5555, 16'h1357, 16'h1357, 16'h1357, 16'h1357,
                                          16'h1357, 16'h00FF, 16'h00FF};
  localparam logic [W-1:0] V_EXP [NV] = '{16'h1234, 16'hEDCB, 16'h0000, 16'h0000, 16'h5555,
                                          16'h0000, 16'h1357, 16'hAAAA, 16'h1357, 16'hAAAA,
                                          16'h0000, 16'h0000, 16'hFF00};
  localparam string V_REQ [NV] = '{"R3", "R4", "R5", "R6", "R6", "R7", "R7",
                                   "R8", "R8", "R8", "R9", "R9", "R4"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", cfg_rdata, 8'h02);
    check("R1", data_out, 16'h0000);
    check("R1", fifo_rst_pulse, 1'b0);
    check("R1", fifo_auto_rst_en, 1'b1);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      write_cfg(V_CFG[i]);
      check("R12", cfg_rdata, V_CFG[i] & 8'h7F);
      los_in  = V_LOS[i];
      lol_in  = V_LOL[i];
      data_in = V_DIN[i];
      @(negedge clk);
      check(V_REQ[i], data_out, V_EXP[i]);
    end

    // R3 latency: output must not change before the edge
    write_cfg(8'h02);
    los_in = 1'b0; lol_in = 1'b0;
    data_in = 16'hC0DE;
    @(negedge clk);
    check("R3", data_out, 16'hC0DE);
    data_in = 16'hBEEF;
    #1;
    check("R3", data_out, 16'hC0DE);
    @(negedge clk);
    check("R3", data_out, 16'hBEEF);

    // R2 and R10: write all ones
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'hFF;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R2", cfg_rdata[7], 1'b0);
    check("R10", fifo_rst_pulse, 1'b1);
    check("R10", cfg_rdata[0], 1'b1);
    @(negedge clk);
    check("R10", fifo_rst_pulse, 1'b0);
    check("R10", cfg_rdata, 8'h7E);

    // R11: auto reset enable off, then on
    write_cfg(8'h00);
    check("R11", fifo_auto_rst_en, 1'b0);
    check("R10", fifo_rst_pulse, 1'b0);
    write_cfg(8'h02);
    check("R11", fifo_auto_rst_en, 1'b1);

    // R5: forced squelch with both flags clear
    write_cfg(8'h04);
    los_in = 1'b0; lol_in = 1'b0; data_in = 16'h8001;
    @(negedge clk);
    check("R5", data_out, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule